// File: doc/BRIEF.md
# Duty-Cycle Gain Generator

This block sits beside two three-channel tone generators and turns the 4-bit duty codes they publish on their I/O ports into gain values. Each generator has two write ports. Port A carries the duty codes of its first two channels. Port B carries the third channel's code and a 3-bit level field. On the second generator, port B also carries a mute flag.

The mapping from a duty code to a gain is not linear. A 160-bit modulation pattern, stored as 20 bytes in an external synchronous ROM, decides it. For a count v, the gain is the share of the pattern that has been walked when the v-th one-to-zero transition appears. After reset the block walks the pattern once, one bit per clock. During that walk it fills a 16-entry gain table and then raises a ready flag. From then on, each of the six registered gain outputs follows its channel's current code through the table.

Top module: `duty_gain_gen`

## Requirements
- R1: A write to a generator's port A loads data bits 3:0 as the duty code of that generator's channel 0 and bits 7:4 as the code of its channel 1. Generator g drives gain outputs 3g, 3g+1 and 3g+2, each in an 8-bit slice of `gain_o`, channel i at bits 8i+7:8i.
- R2: A write to port B loads bits 3:0 as the code of the generator's channel 2 and bits 6:4 into that generator's `level_o` field (generator g at bits 3g+2:3g).
- R3: Bit 7 of a port B write to generator 1 sets or clears a mute that forces all six gains to 0. Bit 7 on generator 0's port B has no effect.
- R4: Pattern bit c (0..159) is bit 7-(c mod 8) of the ROM byte at address c/8, so each byte is consumed MSB first. The ROM returns data one clock after the address.
- R5: Table entry 15-v holds floor(p*100/160). Here p is one more than the bit index at which the v-th 1-to-0 transition is seen, counting with a previous bit that starts at 1, so a leading 0 counts as a transition. Entry 15 (v = 0) is 0. The 8-bit value is the percentage divided by 4, with 2 fractional bits.
- R6: An entry whose transition count is never reached within the 160 bits holds 100 (p = 160).
- R7: After reset, `table_ready` stays low and all gains read 0 until the table is complete. Completion comes within 250 clocks, and after that `table_ready` stays high until the next reset.
- R8: A gain output reflects a port write on the second rising edge after the edge that samples the write strobe.
- R9: Reset clears all duty codes, level fields and the mute, and drives all gain outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_a | input | 2 | Port A write strobe, one bit per generator |
| data_a | input | 16 | Port A write data, generator g at bits 8g+7:8g |
| wr_b | input | 2 | Port B write strobe, one bit per generator |
| data_b | input | 16 | Port B write data, generator g at bits 8g+7:8g |
| rom_addr | output | 5 | Pattern ROM byte address |
| rom_data | input | 8 | Pattern ROM byte, valid one clock after the address |
| gain_o | output | 48 | Six registered gains, 8 bits each |
| level_o | output | 6 | Level field of each generator, 3 bits each |
| table_ready | output | 1 | Gain table built |

## Verification
Three kinds of event can coincide. Port writes can arrive while the pattern walk is still filling the table. The mute and duty changes can land in the same write cycle. All four write ports can be strobed in one clock. The bench provokes each case on purpose: it writes a code during the build, it sets the mute together with a port A write on the other generator, and it strobes all four ports at once. A behavioural reference table is derived from the ROM bytes with a bit-walk loop, and a reference pipeline is compared against every gain output on every clock. This shows that gains stay 0 until ready, that a muted cycle hides the newly loaded codes, and that simultaneous writes land on the right channels.

// File: rtl/dgg_pkg.sv
package dgg_pkg;
  localparam int BYTE_W     = 8;
  localparam int DUTY_W     = 4;
  localparam int GAIN_W     = 8;
  localparam int LEVEL_W    = 3;
  localparam int CH_PER_GEN = 3;

  typedef enum logic [1:0] {SC_REQ, SC_LOAD, SC_BITS, SC_DONE} scan_st_t;

  // Percentage of the pattern covered by pos bits, truncated; with the
  // /4 scaling and 2 fraction bits the stored code equals this integer.
  function automatic logic [GAIN_W-1:0] pct_of(input int unsigned pos,
                                               input int unsigned total);
    int unsigned q;
    q = (pos * 100) / total;
    return q[GAIN_W-1:0];
  endfunction
endpackage

// File: rtl/dgg_port_capture.sv
module dgg_port_capture
  import dgg_pkg::*;
#(
  parameter bit OWNS_MUTE = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_a,
  input  logic [BYTE_W-1:0]              data_a,
  input  logic                           wr_b,
  input  logic [BYTE_W-1:0]              data_b,
  output logic [CH_PER_GEN*DUTY_W-1:0]   duty_o,
  output logic [LEVEL_W-1:0]             level_o,
  output logic                           mute_o
);
  logic [DUTY_W-1:0]  duty_q [CH_PER_GEN];
  logic [LEVEL_W-1:0] level_q;
  logic               flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CH_PER_GEN; c++) duty_q[c] <= '0;
      level_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_a) begin
        duty_q[0] <= data_a[DUTY_W-1:0];
        duty_q[1] <= data_a[2*DUTY_W-1:DUTY_W];
      end
      if (wr_b) begin
        duty_q[2] <= data_b[DUTY_W-1:0];
        level_q   <= data_b[DUTY_W+LEVEL_W-1:DUTY_W];
        flag_q    <= data_b[BYTE_W-1];
      end
    end
  end

  for (genvar c = 0; c < CH_PER_GEN; c++) begin : g_flat
    assign duty_o[c*DUTY_W +: DUTY_W] = duty_q[c];
  end
  assign level_o = level_q;
  assign mute_o  = OWNS_MUTE ? flag_q : 1'b0;

  p_duty_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_a |=> $stable(duty_o[2*DUTY_W-1:0]));
  p_level_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_b |=> level_o == $past(data_b[DUTY_W+LEVEL_W-1:DUTY_W]));
endmodule

// File: rtl/dgg_pattern_scanner.sv
module dgg_pattern_scanner
  import dgg_pkg::*;
#(
  parameter int PATTERN_BYTES = 20,
  parameter int ENTRIES       = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  output logic [$clog2(PATTERN_BYTES)-1:0]   rom_addr_o,
  input  logic [BYTE_W-1:0]                  rom_data_i,
  output logic                               wr_en_o,
  output logic [$clog2(ENTRIES)-1:0]         wr_idx_o,
  output logic [GAIN_W-1:0]                  wr_val_o,
  output logic                               done_o
);
  localparam int PATTERN_BITS = PATTERN_BYTES * BYTE_W;
  localparam int AW           = $clog2(PATTERN_BYTES);
  localparam int IW           = $clog2(ENTRIES);
  localparam int PW           = $clog2(PATTERN_BITS + 1);
  localparam int BW           = $clog2(BYTE_W);
  localparam int LAST_BYTE    = PATTERN_BYTES - 1;
  localparam int MAX_FALLS    = ENTRIES - 1;

  scan_st_t          st_q;
  logic [AW-1:0]     byte_q;
  logic [BW-1:0]     bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              prev_q;
  logic [IW-1:0]     falls_q;
  logic [PW-1:0]     pos_q;

  logic cur_bit, is_fall, take;

  always_comb begin
    cur_bit  = sh_q[BYTE_W-1];
    is_fall  = (st_q == SC_BITS) && prev_q && !cur_bit;
    take     = is_fall && (falls_q != IW'(MAX_FALLS));
    wr_en_o  = take;
    wr_idx_o = IW'(MAX_FALLS) - falls_q - IW'(1);
    wr_val_o = pct_of(32'(pos_q) + 32'd1, PATTERN_BITS);
  end

  assign rom_addr_o = byte_q;
  assign done_o     = (st_q == SC_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SC_REQ;
      byte_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      prev_q  <= 1'b1;
      falls_q <= '0;
      pos_q   <= '0;
    end else begin
      unique case (st_q)
        SC_REQ:  st_q <= SC_LOAD;
        SC_LOAD: begin
          sh_q  <= rom_data_i;
          bit_q <= '0;
          st_q  <= SC_BITS;
        end
        SC_BITS: begin
          sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
          prev_q <= cur_bit;
          pos_q  <= pos_q + PW'(1);
          bit_q  <= bit_q + BW'(1);
          if (take) falls_q <= falls_q + IW'(1);
          if (bit_q == BW'(BYTE_W - 1)) begin
            if (byte_q == AW'(LAST_BYTE)) begin
              st_q <= SC_DONE;
            end else begin
              byte_q <= byte_q + AW'(1);
              st_q   <= SC_REQ;
            end
          end
        end
        default: st_q <= SC_DONE;
      endcase
    end
  end

  p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
    rom_addr_o < AW'(PATTERN_BYTES));
  p_pos_bound_r6: assert property (@(posedge clk) disable iff (rst)
    pos_q <= PW'(PATTERN_BITS));
  p_top_entry_kept_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> wr_idx_o != IW'(MAX_FALLS));
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
endmodule

// File: rtl/dgg_gain_table.sv
module dgg_gain_table
  import dgg_pkg::*;
#(
  parameter int               ENTRIES   = 16,
  parameter int               READS     = 6,
  parameter logic [GAIN_W-1:0] UNREACHED = 8'd100
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [$clog2(ENTRIES)-1:0]        wr_idx,
  input  logic [GAIN_W-1:0]                 wr_val,
  input  logic [READS*$clog2(ENTRIES)-1:0]  rd_idx,
  output logic [READS*GAIN_W-1:0]           rd_val
);
  localparam int IW = $clog2(ENTRIES);

  logic [GAIN_W-1:0] tbl_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++)
        tbl_q[e] <= (e == ENTRIES - 1) ? '0 : UNREACHED;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_val;
    end
  end

  for (genvar r = 0; r < READS; r++) begin : g_rd
    assign rd_val[r*GAIN_W +: GAIN_W] = tbl_q[rd_idx[r*IW +: IW]];
  end

  p_write_bound_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_val <= UNREACHED);
endmodule

// File: rtl/duty_gain_gen.sv
module duty_gain_gen
  import dgg_pkg::*;
#(
  parameter int NUM_GEN       = 2,
  parameter int PATTERN_BYTES = 20
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [NUM_GEN-1:0]                     wr_a,
  input  logic [NUM_GEN*BYTE_W-1:0]              data_a,
  input  logic [NUM_GEN-1:0]                     wr_b,
  input  logic [NUM_GEN*BYTE_W-1:0]              data_b,
  output logic [$clog2(PATTERN_BYTES)-1:0]       rom_addr,
  input  logic [BYTE_W-1:0]                      rom_data,
  output logic [NUM_GEN*CH_PER_GEN*GAIN_W-1:0]   gain_o,
  output logic [NUM_GEN*LEVEL_W-1:0]             level_o,
  output logic                                   table_ready
);
  localparam int NUM_CH       = NUM_GEN * CH_PER_GEN;
  localparam int ENTRIES      = 1 << DUTY_W;
  localparam int PATTERN_BITS = PATTERN_BYTES * BYTE_W;
  localparam logic [GAIN_W-1:0] UNREACHED = pct_of(PATTERN_BITS, PATTERN_BITS);
  localparam int GEN_DW       = CH_PER_GEN * DUTY_W;

  logic [NUM_CH*DUTY_W-1:0] duty_all;
  logic [NUM_GEN-1:0]       mute_vec;
  logic                     mute_any;
  logic                     wr_en;
  logic [DUTY_W-1:0]        wr_idx;
  logic [GAIN_W-1:0]        wr_val;
  logic [NUM_CH*GAIN_W-1:0] looked_up;
  logic [NUM_CH*GAIN_W-1:0] gain_q;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    dgg_port_capture #(.OWNS_MUTE(g == NUM_GEN - 1)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .wr_a    (wr_a[g]),
      .data_a  (data_a[g*BYTE_W +: BYTE_W]),
      .wr_b    (wr_b[g]),
      .data_b  (data_b[g*BYTE_W +: BYTE_W]),
      .duty_o  (duty_all[g*GEN_DW +: GEN_DW]),
      .level_o (level_o[g*LEVEL_W +: LEVEL_W]),
      .mute_o  (mute_vec[g])
    );
  end

  assign mute_any = |mute_vec;

  dgg_pattern_scanner #(
    .PATTERN_BYTES (PATTERN_BYTES),
    .ENTRIES       (ENTRIES)
  ) u_scan (
    .clk        (clk),
    .rst        (rst),
    .rom_addr_o (rom_addr),
    .rom_data_i (rom_data),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_val_o   (wr_val),
    .done_o     (table_ready)
  );

  dgg_gain_table #(
    .ENTRIES   (ENTRIES),
    .READS     (NUM_CH),
    .UNREACHED (UNREACHED)
  ) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_val (wr_val),
    .rd_idx (duty_all),
    .rd_val (looked_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++)
        gain_q[ch*GAIN_W +: GAIN_W] <= (table_ready && !mute_any)
                                       ? looked_up[ch*GAIN_W +: GAIN_W] : '0;
    end
  end

  assign gain_o = gain_q;

  p_silent_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !table_ready |-> gain_o == '0);
  p_mute_silences_r3: assert property (@(posedge clk) disable iff (rst)
    mute_any |=> gain_o == '0);
endmodule

// File: tb/tb_duty_gain_gen.sv
module tb_duty_gain_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  wr_a = '0, wr_b = '0;
  logic [15:0] data_a = '0, data_b = '0;
  logic [4:0]  rom_addr;
  logic [7:0]  rom_q;
  logic [47:0] gain_o;
  logic [5:0]  level_o;
  logic        table_ready;

  logic [7:0] rom_mem [20];
  int  ref_tbl [16];
  int  m_duty [6];
  int  exp_gain [6];
  int  m_level [2];
  bit  m_mute;
  bit  rdy_seen;
  int  n_tests, n_fail;
  bit  ended;

  always #5 clk = ~clk;

  duty_gain_gen dut (
    .clk(clk), .rst(rst), .wr_a(wr_a), .data_a(data_a), .wr_b(wr_b),
    .data_b(data_b), .rom_addr(rom_addr), .rom_data(rom_q),
    .gain_o(gain_o), .level_o(level_o), .table_ready(table_ready)
  );

  always @(posedge clk) rom_q <= rom_mem[rom_addr];

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Behavioural table: walk the bits separately for every count v.
  task automatic build_ref();
    for (int v = 0; v < 16; v++) begin
      int left = v, prev = 1, c = 0, cur;
      while (c < 160 && left > 0) begin
        cur = (rom_mem[c / 8] >> (7 - c % 8)) & 1;
        if (cur == 0 && prev != 0) left--;
        prev = cur;
        c++;
      end
      ref_tbl[15 - v] = (c * 100) / 160;
    end
  endtask

  // Reference pipeline: codes register at one edge, gains at the next.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin m_duty[i] <= 0; exp_gain[i] <= 0; end
      m_level[0] <= 0; m_level[1] <= 0; m_mute <= 0;
    end else begin
      for (int i = 0; i < 6; i++)
        exp_gain[i] <= (rdy_seen && !m_mute) ? ref_tbl[m_duty[i]] : 0;
      for (int g = 0; g < 2; g++) begin
        if (wr_a[g]) begin
          m_duty[g*3]   <= int'(data_a[g*8 +: 4]);
          m_duty[g*3+1] <= int'(data_a[g*8+4 +: 4]);
        end
        if (wr_b[g]) begin
          m_duty[g*3+2] <= int'(data_b[g*8 +: 4]);
          m_level[g]    <= int'(data_b[g*8+4 +: 3]);
          if (g == 1) m_mute <= data_b[15];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 6; i++)
        chk("R1/R5 per-cycle gain", int'(gain_o[i*8 +: 8]), exp_gain[i]);
      for (int g = 0; g < 2; g++)
        chk("R2 per-cycle level", int'(level_o[g*3 +: 3]), m_level[g]);
      if (rdy_seen) chk("R7 ready held", int'(table_ready), 1);
    end
    rdy_seen = rst ? 1'b0 : table_ready;
  end

  task automatic strobe(bit port_b, int g, int val);
    if (port_b) begin wr_b[g] = 1'b1; data_b[g*8 +: 8] = 8'(val); end
    else        begin wr_a[g] = 1'b1; data_a[g*8 +: 8] = 8'(val); end
    @(negedge clk);
    wr_a = '0; wr_b = '0;
  endtask

  function automatic int gch(int ch);
    return int'(gain_o[ch*8 +: 8]);
  endfunction

  task automatic wait_ready();
    int cyc = 0;
    while (!table_ready && cyc < 400) begin
      chk("R7 silent while building", int'(gain_o != 0), 0);
      @(negedge clk); cyc++;
    end
    chk("R7 build within 250 clocks", int'(cyc <= 250), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R7 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 20; i++) rom_mem[i] = 8'((i * 73 + 29) ^ (i * i * 5));
    build_ref();
    repeat (4) @(negedge clk);
    chk("R9 reset gains", int'(gain_o != 0), 0);
    chk("R9 reset levels", int'(level_o), 0);
    chk("R7 ready low in reset", int'(table_ready), 0);
    rst = 1'b0;
    strobe(0, 0, 8'h5A);                 // written while table builds
    wait_ready();
    chk("R1 ch0 code from build-time write", gch(0), ref_tbl[10]);
    chk("R1 ch1 code from build-time write", gch(1), ref_tbl[5]);

    for (int code = 0; code < 16; code++) begin
      strobe(0, 0, code | ((15 - code) << 4));
      if (code == 3) chk("R8 old value one edge later", gch(0), ref_tbl[2]);
      @(negedge clk);
      chk("R5 sweep ch0", gch(0), ref_tbl[code]);
      chk("R5 sweep ch1", gch(1), ref_tbl[15 - code]);
    end

    // all four ports strobed in one clock
    wr_a = 2'b11; wr_b = 2'b11;
    data_a = 16'h1234; data_b = 16'h5667;
    @(negedge clk); wr_a = '0; wr_b = '0;
    @(negedge clk);
    chk("R1 g1 ch0", gch(3), ref_tbl[2]);
    chk("R1 g1 ch1", gch(4), ref_tbl[1]);
    chk("R2 g0 ch2", gch(2), ref_tbl[7]);
    chk("R2 g1 ch2", gch(5), ref_tbl[6]);
    chk("R2 level g0", int'(level_o[2:0]), 6);
    chk("R2 level g1", int'(level_o[5:3]), 5);

    strobe(1, 0, 8'hB3);                 // bit 7 on generator 0: no mute
    @(negedge clk);
    chk("R3 gen0 bit7 ignored", gch(2), ref_tbl[3]);

    wr_b[1] = 1'b1; data_b[15:8] = 8'h84;  // mute with a same-cycle code change
    wr_a[0] = 1'b1; data_a[7:0] = 8'h9C;
    @(negedge clk); wr_a = '0; wr_b = '0;
    @(negedge clk);
    chk("R3 muted gains zero", int'(gain_o != 0), 0);
    strobe(1, 1, 8'h25);
    @(negedge clk);
    chk("R3 unmute ch5", gch(5), ref_tbl[5]);
    chk("R3 unmute ch0", gch(0), ref_tbl[12]);
    chk("R2 level after unmute", int'(level_o[5:3]), 2);

    // second pattern: two falling transitions only
    rst = 1'b1;
    for (int i = 0; i < 20; i++) rom_mem[i] = 8'hFF;
    rom_mem[1] = 8'hEF; rom_mem[5] = 8'h00;
    build_ref();
    repeat (3) @(negedge clk);
    chk("R9 reset clears gains again", int'(gain_o != 0), 0);
    rst = 1'b0;
    wait_ready();
    strobe(0, 0, 8'hDE);
    strobe(1, 0, 8'h00);
    strobe(0, 1, 8'hCF);
    @(negedge clk);
    chk("R4 MSB-first first fall", gch(0), 7);
    chk("R4 second fall", gch(1), 25);
    chk("R6 unreached code 0", gch(2), 100);
    chk("R5 code 15 is zero", gch(3), 0);
    chk("R6 unreached code 12", gch(4), 100);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule